// File: doc/BRIEF.md
# Bus Release and Refresh Arbiter

This block decides who drives a shared external memory bus. The local bus master holds the bus by default. An external master may ask for the bus, and a refresh timer may ask for a memory refresh cycle. Ownership changes only at a safe boundary: the end of a local bus cycle while no locked sequence is in progress. The local sequencer raises a lock input for the whole of every sequence that must not be split. These are narrow-bus split accesses, 32-byte line transfers, atomic read-modify-write pairs and the read/write halves of dual-address DMA.

A refresh request is latched and is never lost. It wins over an external request at the same boundary. While the bus is lent out, refresh waits. A pending refresh makes the block withdraw its grant, and the refresh runs once the external master has dropped its request. When the SDRAM row-held-open mode is on, the block spends one cycle asking for a precharge-all before each refresh and before each grant. The SDRAM command timing stays outside the block.

Top module: `bus_release_arb`

## Requirements
- R1: After a synchronous reset, owner_o is 00, ext_gnt_o is 0 and pall_req_o is 0.
- R2: Ownership leaves the local master only on a clock edge where cyc_end_i is 1 and lock_i is 0. With lock_i at 1, or without cyc_end_i, pending requests leave owner_o at 00.
- R3: With row-open mode off, an external request seen at a safe boundary raises ext_gnt_o, with owner_o = 01 (external), in the next cycle.
- R4: When ext_req_i goes low while the grant is held, ext_gnt_o falls in the next cycle and owner_o returns to 00.
- R5: A refresh started with row-open mode off shows owner_o = 10 (refresh) from the cycle after the decision. It stays at 10 until rfsh_done_i is sampled high, and owner_o is 00 in the next cycle.
- R6: When a refresh and an external request are both pending at one safe boundary, the refresh is started and no grant is given.
- R7: While the bus is released, refresh does not start. A pending refresh drops ext_gnt_o in the next cycle while owner_o stays 01. The refresh (owner_o = 10) begins in the cycle after ext_req_i is sampled low.
- R8: A one-cycle refresh request that arrives during a lock or during a release is held until it is serviced.
- R9: With row_open_i = 1, each refresh and each grant is preceded by exactly one cycle with pall_req_o = 1 and owner_o = 00.
- R10: A safe boundary with nothing pending leaves owner_o at 00 and ext_gnt_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_req_i | input | 1 | External master bus request (level) |
| ext_gnt_o | output | 1 | Bus granted to external master |
| rfsh_req_i | input | 1 | Refresh request pulse from refresh timer |
| rfsh_done_i | input | 1 | Refresh cycle finished |
| cyc_end_i | input | 1 | Pulse at the end of each local bus cycle |
| lock_i | input | 1 | Local locked sequence in progress |
| row_open_i | input | 1 | SDRAM row-held-open mode enabled |
| pall_req_o | output | 1 | Precharge-all request |
| owner_o | output | 2 | Bus owner: 00 local, 01 external, 10 refresh |

## Verification
Directed sequences set lock against cycle-end pulses, which separates a real safe boundary from a plain cycle end. Refresh pulses go in during a lock and during a release, which shows whether a request is lost or wrongly serviced early. Simultaneous refresh and external requests test the priority, and the same flows run again with row-open mode on to confirm the extra precharge cycle. A long constrained-random run then mixes all inputs, and a cycle-accurate model in the bench checks every output each cycle.

// File: rtl/bus_release_arb_pkg.sv
package bus_release_arb_pkg;

    typedef enum logic [2:0] {
        ST_LOCAL    = 3'd0,
        ST_PALL_EXT = 3'd1,
        ST_EXT      = 3'd2,
        ST_RECLAIM  = 3'd3,
        ST_PALL_RF  = 3'd4,
        ST_RFSH     = 3'd5
    } arb_st_e;

    localparam int OWNER_W = 2;

    typedef enum logic [OWNER_W-1:0] {
        OWN_LOCAL = 2'b00,
        OWN_EXT   = 2'b01,
        OWN_RFSH  = 2'b10
    } owner_e;

    typedef struct packed {
        logic ext_req;
        logic rf_any;
        logic safe;
        logic rf_done;
        logic row_mode;
    } arb_in_t;

    function automatic owner_e owner_of(arb_st_e st);
        case (st)
            ST_EXT, ST_RECLAIM: return OWN_EXT;
            ST_RFSH:            return OWN_RFSH;
            default:            return OWN_LOCAL;
        endcase
    endfunction

endpackage

// File: rtl/arb_safe_gate.sv
module arb_safe_gate (
    input  logic cyc_end_i,
    input  logic lock_i,
    output logic safe_o
);
    always_comb safe_o = cyc_end_i & ~lock_i;
endmodule

// File: rtl/arb_rfsh_latch.sv
module arb_rfsh_latch (
    input  logic clk,
    input  logic rst,
    input  logic rf_i,
    input  logic clr_i,
    output logic pend_o,
    output logic any_o
);
    always_ff @(posedge clk) begin
        if (rst)        pend_o <= 1'b0;
        else if (clr_i) pend_o <= 1'b0;
        else if (rf_i)  pend_o <= 1'b1;
    end

    always_comb any_o = pend_o | rf_i;

    AST_RF_KEPT: assert property (@(posedge clk) disable iff (rst)
        (rf_i && !clr_i) |=> pend_o); // R8
endmodule

// File: rtl/arb_fsm.sv
module arb_fsm
    import bus_release_arb_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  arb_in_t in_i,
    output arb_st_e st_o,
    output logic    rf_clr_o
);
    arb_st_e st_n;

    always_comb begin
        st_n = st_o;
        case (st_o)
            ST_LOCAL: begin
                if (in_i.safe && in_i.rf_any)
                    st_n = in_i.row_mode ? ST_PALL_RF : ST_RFSH;
                else if (in_i.safe && in_i.ext_req)
                    st_n = in_i.row_mode ? ST_PALL_EXT : ST_EXT;
            end
            ST_PALL_EXT: st_n = ST_EXT;
            ST_EXT: begin
                if (!in_i.ext_req)    st_n = ST_LOCAL;
                else if (in_i.rf_any) st_n = ST_RECLAIM;
            end
            ST_RECLAIM: begin
                if (!in_i.ext_req)
                    st_n = in_i.row_mode ? ST_PALL_RF : ST_RFSH;
            end
            ST_PALL_RF: st_n = ST_RFSH;
            ST_RFSH: begin
                if (in_i.rf_done) st_n = ST_LOCAL;
            end
            default: st_n = ST_LOCAL;
        endcase
    end

    always_comb rf_clr_o = (st_o == ST_LOCAL || st_o == ST_RECLAIM) &&
                           (st_n == ST_PALL_RF || st_n == ST_RFSH);

    always_ff @(posedge clk) begin
        if (rst) st_o <= ST_LOCAL;
        else     st_o <= st_n;
    end

    AST_HOLD_LOCAL: assert property (@(posedge clk) disable iff (rst)
        (st_o == ST_LOCAL && !in_i.safe) |=> st_o == ST_LOCAL); // R2
    AST_RF_FIRST: assert property (@(posedge clk) disable iff (rst)
        (st_o == ST_LOCAL && in_i.safe && in_i.rf_any) |=> (st_o == ST_PALL_RF || st_o == ST_RFSH)); // R6
    AST_NO_RF_IN_REL: assert property (@(posedge clk) disable iff (rst)
        (st_o == ST_RECLAIM && in_i.ext_req) |=> st_o == ST_RECLAIM); // R7
endmodule

// File: rtl/arb_out_decode.sv
module arb_out_decode
    import bus_release_arb_pkg::*;
(
    input  arb_st_e              st_i,
    output logic                 gnt_o,
    output logic                 pall_o,
    output logic [OWNER_W-1:0]   owner_o
);
    always_comb begin
        gnt_o   = (st_i == ST_EXT);
        pall_o  = (st_i == ST_PALL_EXT) || (st_i == ST_PALL_RF);
        owner_o = owner_of(st_i);
    end
endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb
    import bus_release_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_req_i,
    output logic                ext_gnt_o,
    input  logic                rfsh_req_i,
    input  logic                rfsh_done_i,
    input  logic                cyc_end_i,
    input  logic                lock_i,
    input  logic                row_open_i,
    output logic                pall_req_o,
    output logic [OWNER_W-1:0]  owner_o
);
    logic    safe, rf_pend, rf_any, rf_clr;
    arb_in_t fsm_in;
    arb_st_e st;

    arb_safe_gate u_gate (
        .cyc_end_i (cyc_end_i),
        .lock_i    (lock_i),
        .safe_o    (safe)
    );

    arb_rfsh_latch u_rf (
        .clk    (clk),
        .rst    (rst),
        .rf_i   (rfsh_req_i),
        .clr_i  (rf_clr),
        .pend_o (rf_pend),
        .any_o  (rf_any)
    );

    always_comb begin
        fsm_in.ext_req  = ext_req_i;
        fsm_in.rf_any   = rf_any;
        fsm_in.safe     = safe;
        fsm_in.rf_done  = rfsh_done_i;
        fsm_in.row_mode = row_open_i;
    end

    arb_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_i     (fsm_in),
        .st_o     (st),
        .rf_clr_o (rf_clr)
    );

    arb_out_decode u_dec (
        .st_i    (st),
        .gnt_o   (ext_gnt_o),
        .pall_o  (pall_req_o),
        .owner_o (owner_o)
    );

    AST_GNT_DROP: assert property (@(posedge clk) disable iff (rst)
        (ext_gnt_o && !ext_req_i) |=> (!ext_gnt_o && owner_o == OWN_LOCAL)); // R4
    AST_RECLAIM: assert property (@(posedge clk) disable iff (rst)
        (ext_gnt_o && ext_req_i && (rf_pend || rfsh_req_i)) |=> (!ext_gnt_o && owner_o == OWN_EXT)); // R7
    AST_PALL_BEFORE_GNT: assert property (@(posedge clk) disable iff (rst)
        ($rose(ext_gnt_o) && row_open_i && $past(row_open_i)) |-> $past(pall_req_o)); // R9
    AST_EXCL_OUT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_gnt_o, pall_req_o, owner_o == OWN_RFSH})); // R9
    AST_PALL_LOCAL: assert property (@(posedge clk) disable iff (rst)
        pall_req_o |-> owner_o == OWN_LOCAL); // R9
endmodule

// File: tb/bus_release_arb_tb_top.sv
module bus_release_arb_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_req = 0, rf_req = 0, rf_done = 0, cyc_end = 0, lock = 0, row_open = 0;
    logic ext_gnt, pall;
    logic [1:0] owner;

    int n_chk = 0;
    int n_bad = 0;
    int m_st = 0;
    bit m_pend = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_release_arb dut_i (
        .clk(clk), .rst(rst), .ext_req_i(ext_req), .ext_gnt_o(ext_gnt),
        .rfsh_req_i(rf_req), .rfsh_done_i(rf_done), .cyc_end_i(cyc_end),
        .lock_i(lock), .row_open_i(row_open), .pall_req_o(pall), .owner_o(owner)
    );

    // model states: 0 local, 1 precharge->ext, 2 ext, 3 reclaim, 4 precharge->refresh, 5 refresh
    function automatic int m_next(int s, bit e, bit rany, bit sf, bit d, bit md);
        case (s)
            0: if (sf && rany) return md ? 4 : 5;
               else if (sf && e) return md ? 1 : 2;
               else return 0;
            1: return 2;
            2: if (!e) return 0; else if (rany) return 3; else return 2;
            3: if (!e) return md ? 4 : 5; else return 3;
            4: return 5;
            default: return d ? 0 : 5;
        endcase
    endfunction

    function automatic bit [1:0] m_owner(int s);
        return (s == 2 || s == 3) ? 2'b01 : (s == 5 ? 2'b10 : 2'b00);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        check("R3 grant vs model", {31'd0, ext_gnt}, {31'd0, m_st == 2});
        check("R5 owner vs model", {30'd0, owner}, {30'd0, m_owner(m_st)});
        check("R9 pall vs model", {31'd0, pall}, {31'd0, m_st == 1 || m_st == 4});
    endtask

    task automatic cyc(bit e, bit r, bit c, bit l, bit d);
        int ns;
        bit rany;
        @(negedge clk);
        ext_req = e; rf_req = r; cyc_end = c; lock = l; rf_done = d;
        rany = m_pend | r;
        ns = m_next(m_st, e, rany, c & ~l, d, row_open);
        if ((m_st == 0 || m_st == 3) && (ns == 4 || ns == 5)) m_pend = 0;
        else m_pend = rany;
        m_st = ns;
        @(posedge clk);
        #1;
        cmp_model();
    endtask

    task automatic expect_out(string tag, bit [1:0] ow, bit g, bit p);
        check(tag, {28'd0, ow, g, p}, {28'd0, owner, ext_gnt, pall});
        check(tag, {30'd0, owner}, {30'd0, ow});
        check(tag, {31'd0, ext_gnt}, {31'd0, g});
        check(tag, {31'd0, pall}, {31'd0, p});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int seed;
        bit e;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        expect_out("R1 reset", 2'b00, 0, 0);

        // R2: lock blocks, plain cycle without end blocks
        cyc(1, 0, 1, 1, 0); expect_out("R2 locked end", 2'b00, 0, 0);
        cyc(1, 0, 0, 0, 0); expect_out("R2 no cycle end", 2'b00, 0, 0);
        // R3: grant at safe boundary
        cyc(1, 0, 1, 0, 0); expect_out("R3 grant", 2'b01, 1, 0);
        // R7: refresh while released reclaims
        cyc(1, 1, 0, 0, 0); expect_out("R7 grant withdrawn", 2'b01, 0, 0);
        cyc(1, 0, 1, 0, 0); expect_out("R7 wait for ext drop", 2'b01, 0, 0);
        cyc(0, 0, 0, 0, 0); expect_out("R7 refresh after drop", 2'b10, 0, 0);
        cyc(0, 0, 0, 0, 0); expect_out("R5 refresh held", 2'b10, 0, 0);
        cyc(0, 0, 0, 0, 1); expect_out("R5 refresh done", 2'b00, 0, 0);
        // R4: grant then drop
        cyc(1, 0, 1, 0, 0); expect_out("R3 grant again", 2'b01, 1, 0);
        cyc(0, 0, 0, 0, 0); expect_out("R4 grant drop", 2'b00, 0, 0);
        // R8 + R6: refresh pulse during lock, then both pending
        cyc(0, 1, 1, 1, 0); expect_out("R8 deferred in lock", 2'b00, 0, 0);
        cyc(1, 0, 0, 1, 0); expect_out("R8 still deferred", 2'b00, 0, 0);
        cyc(1, 0, 1, 0, 0); expect_out("R6 refresh wins", 2'b10, 0, 0);
        cyc(1, 0, 0, 0, 1); expect_out("R5 back to local", 2'b00, 0, 0);
        cyc(1, 0, 1, 0, 0); expect_out("R3 grant after refresh", 2'b01, 1, 0);
        // R8: pulse during release is kept
        cyc(1, 1, 0, 0, 0); expect_out("R8 reclaim on pulse", 2'b01, 0, 0);
        cyc(0, 0, 0, 0, 0); expect_out("R8 refresh runs", 2'b10, 0, 0);
        cyc(0, 0, 0, 0, 1); expect_out("R5 done", 2'b00, 0, 0);
        // R10: idle boundary
        cyc(0, 0, 1, 0, 0); expect_out("R10 idle boundary", 2'b00, 0, 0);
        // R9: row-open mode
        row_open = 1;
        cyc(0, 1, 1, 0, 0); expect_out("R9 precharge before refresh", 2'b00, 0, 1);
        cyc(0, 0, 0, 0, 0); expect_out("R9 refresh after precharge", 2'b10, 0, 0);
        cyc(0, 0, 0, 0, 1); expect_out("R9 done", 2'b00, 0, 0);
        cyc(1, 0, 1, 0, 0); expect_out("R9 precharge before grant", 2'b00, 0, 1);
        cyc(1, 0, 0, 0, 0); expect_out("R9 grant after precharge", 2'b01, 1, 0);
        cyc(0, 0, 0, 0, 0); expect_out("R4 drop in row mode", 2'b00, 0, 0);

        // constrained random against the model
        e = 0;
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) row_open = $urandom_range(0, 1);
            if ($urandom_range(0, 7) == 0) e = ~e;
            cyc(e, $urandom_range(0, 19) == 0, $urandom_range(0, 2) == 0,
                $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0);
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule